// File: doc/BRIEF.md
# Delayed Read Retry Tracker

This block serves reads from an external bus master as delayed transactions. When a read arrives and nothing is tracked, the block answers with a retry and captures the address. In the same step it launches one internal fetch. The master is expected to repeat the same read. Once the fetched word is held and the repeat matches the captured address, the block answers with the data and becomes free again.

Only one delayed read is tracked at a time. A master that never comes back would otherwise hold the tracker forever. A discard timer therefore runs while fetched data waits. If it runs out, the data is dropped, the tracker returns to idle and a sticky expiry flag is raised. Software clears the flag by writing a 1, which appears here as a clear pulse. The flag is informational only and does not stop new reads.

States and transitions:
- IDLE --read--> FETCHING. The read is answered with a retry and a fetch is issued.
- FETCHING --fetch_done--> READY. The fetched word is stored and the timer starts.
- READY --matching read--> IDLE. The read is answered with the data.
- READY --timer runs out--> IDLE. The data is discarded and the flag is set.
- All other events leave the state unchanged.

Top module: `drd_tracker`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_retry`, `fetch_req` and `exp_flag` are 0.
- R2: A read sampled in IDLE gives a retry response (`rsp_valid`=1, `rsp_retry`=1) in the next cycle. In that same cycle `fetch_req` is 1 for exactly one cycle, with `fetch_addr` equal to the read address.
- R3: Every read sampled in FETCHING gets a retry and raises no `fetch_req`, whether or not its address matches.
- R4: `fetch_done` sampled in FETCHING stores `fetch_data`. A matching read sampled in READY gives `rsp_valid`=1, `rsp_retry`=0 and `rsp_data` equal to the stored word in the next cycle, and the tracker returns to IDLE.
- R5: A read to another address sampled in READY gets a retry, starts no fetch and keeps the stored word for the pending read.
- R6: Let edge E0 be the edge that samples `fetch_done`. A matching read sampled at edges E1 to E(EXPIRE_CYC) is served. A read sampled at E(EXPIRE_CYC+1) or later is treated as a new read.
- R7: If no matching read is sampled by edge E(EXPIRE_CYC), the word is dropped, the tracker returns to IDLE and `exp_flag` reads 1 after that edge.
- R8: `exp_flag` stays 1 until an `exp_clr` pulse, and reads 0 after the edge that samples it. If an expiry and a clear meet at the same edge, the flag ends at 1.
- R9: After an expiry, the next read is handled as a fresh read: retry plus a new fetch. Once that fetch completes, the data is served normally.
- R10: `rsp_valid` is 1 only in the cycle after a sampled read. `rsp_retry` is never 1 without `rsp_valid`. `rsp_data` is 0 in a retry response.
- R11: `fetch_done` sampled outside FETCHING is ignored and does not replace the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read attempt from the master, one cycle per attempt |
| rd_addr | input | ADDR_W | Read address |
| rsp_valid | output | 1 | Response present (one cycle after `rd_req`) |
| rsp_retry | output | 1 | Response is a retry |
| rsp_data | output | DATA_W | Read data when the response is not a retry |
| fetch_req | output | 1 | One-cycle internal fetch request |
| fetch_addr | output | ADDR_W | Captured address of the tracked read |
| fetch_done | input | 1 | Internal fetch result valid |
| fetch_data | input | DATA_W | Internal fetch result |
| exp_flag | output | 1 | Sticky discard-timer expiry flag |
| exp_clr | input | 1 | Write-1-to-clear pulse for `exp_flag` |

## Verification
Every result comes from a register, so the response and `fetch_req` for a read sampled at one edge are due right after that edge. The bench drives inputs 1 ns after a rising edge and checks outputs 1 ns after the next rising edge. The expiry flag is due right after edge E(EXPIRE_CYC). It is checked both there and after several idle cycles. The gap between `fetch_done` and the repeat read is swept from 1 to EXPIRE_CYC+2 with EXPIRE_CYC set to 8. The served-or-retried outcome and the flag value are computed by comparing the gap with the limit.

// File: rtl/drd_pkg.sv
package drd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FETCHING = 2'd1,
        ST_READY    = 2'd2
    } drd_state_e;
endpackage

// File: rtl/drd_timer.sv
module drd_timer #(
    parameter int LIMIT = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && (cnt_q == LAST);
endmodule

// File: rtl/drd_flag.sv
module drd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/drd_fsm.sv
module drd_fsm
    import drd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              fetch_done,
    input  logic [DATA_W-1:0] fetch_data,
    input  logic              expire,
    output logic              in_ready,
    output logic              in_idle,
    output logic              expire_evt,
    output logic              rsp_valid,
    output logic              rsp_retry,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr
);
    drd_state_e        state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              hit;

    assign hit        = rd_req && (rd_addr == fetch_addr) && (state_q == ST_READY);
    assign in_ready   = (state_q == ST_READY);
    assign in_idle    = (state_q == ST_IDLE);
    assign expire_evt = in_ready && expire && !hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (rd_req) state_d = ST_FETCHING;
            ST_FETCHING: if (fetch_done) state_d = ST_READY;
            ST_READY:    if (hit || expire) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_retry  <= 1'b0;
            rsp_data   <= '0;
            fetch_req  <= 1'b0;
            fetch_addr <= '0;
            data_q     <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_retry <= rd_req && !hit;
            rsp_data  <= hit ? data_q : '0;
            fetch_req <= in_idle && rd_req;
            if (in_idle && rd_req) fetch_addr <= rd_addr;
            if ((state_q == ST_FETCHING) && fetch_done) data_q <= fetch_data;
            else if (expire_evt) data_q <= '0;
        end
    end
endmodule

// File: rtl/drd_tracker.sv
module drd_tracker #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int EXPIRE_CYC = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rsp_valid,
    output logic              rsp_retry,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_done,
    input  logic [DATA_W-1:0] fetch_data,
    output logic              exp_flag,
    input  logic              exp_clr
);
    logic in_ready, in_idle, expire, expire_evt;

    drd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .fetch_done(fetch_done), .fetch_data(fetch_data), .expire(expire),
        .in_ready(in_ready), .in_idle(in_idle), .expire_evt(expire_evt),
        .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_data(rsp_data),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr)
    );

    drd_timer #(.LIMIT(EXPIRE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(in_ready), .expire(expire)
    );

    drd_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set(expire_evt), .clr(exp_clr), .flag(exp_flag)
    );
endmodule

// File: rtl/drd_tracker_chk.sv
module drd_tracker_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rsp_valid,
    input logic              rsp_retry,
    input logic [DATA_W-1:0] rsp_data,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              exp_flag,
    input logic              exp_clr,
    input logic              in_idle,
    input logic              expire_evt
);
    a_r2_first_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && in_idle) |=> (rsp_retry && fetch_req && fetch_addr == $past(rd_addr)));

    a_r3_no_refetch: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !in_idle) |=> !fetch_req);

    a_r4_data_match: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_retry) |-> (fetch_addr == $past(rd_addr)));

    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        expire_evt |=> exp_flag);

    a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_clr && !expire_evt) |=> !exp_flag);

    a_r10_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rd_req));

    a_r10_retry_form: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_retry |-> (rsp_valid && rsp_data == '0));
endmodule

bind drd_tracker drd_tracker_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_data(rsp_data),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .exp_flag(exp_flag),
    .exp_clr(exp_clr), .in_idle(in_idle), .expire_evt(expire_evt)
);

// File: tb/drd_tracker_tb.sv
module drd_tracker_tb;
    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int LIM = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rsp_valid, rsp_retry, fetch_req, exp_flag;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] fetch_addr;
    logic          fetch_done = 1'b0;
    logic [DW-1:0] fetch_data = '0;
    logic          exp_clr = 1'b0;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    drd_tracker #(.ADDR_W(AW), .DATA_W(DW), .EXPIRE_CYC(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_data(rsp_data),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_done(fetch_done), .fetch_data(fetch_data),
        .exp_flag(exp_flag), .exp_clr(exp_clr)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // Read attempt; served=1 expects data, else a retry
    task automatic read_op(input logic [AW-1:0] a, input bit served, input logic [DW-1:0] d,
                           input bit exp_fetch, input string tag);
        rd_req = 1'b1; rd_addr = a;
        cyc();
        rd_req = 1'b0;
        chk(rsp_valid == 1'b1, {tag, " valid"}, rsp_valid, 1);
        chk(rsp_retry == !served, {tag, " retry"}, rsp_retry, !served);
        chk(rsp_data == (served ? d : '0), {tag, " data"}, rsp_data, served ? d : 0);
        chk(fetch_req == exp_fetch, {tag, " fetch_req"}, fetch_req, exp_fetch);
        if (exp_fetch) chk(fetch_addr == a, {tag, " fetch_addr"}, fetch_addr, a);
    endtask

    task automatic fetch_op(input logic [DW-1:0] d);
        fetch_done = 1'b1; fetch_data = d;
        cyc();
        fetch_done = 1'b0;
    endtask

    initial begin
        #200000;
        chk(1'b0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        chk(rsp_valid == 0 && rsp_retry == 0, "R1 rsp idle", rsp_valid, 0);
        chk(fetch_req == 0, "R1 fetch_req", fetch_req, 0);
        chk(exp_flag == 0, "R1 exp_flag", exp_flag, 0);

        read_op(16'h00A0, 0, 0, 1, "R2 first read");
        cyc();
        chk(fetch_req == 0 && rsp_valid == 0, "R2 one-cycle pulse R10", fetch_req, 0);

        read_op(16'h00A0, 0, 0, 0, "R3 same addr in fetch");
        read_op(16'h00B0, 0, 0, 0, "R3 other addr in fetch");

        fetch_op(16'h1234);
        read_op(16'h00B0, 0, 0, 0, "R5 other addr ready");
        fetch_op(16'hDEAD);
        read_op(16'h00A0, 1, 16'h1234, 0, "R4 R11 matching read");
        read_op(16'h00A0, 0, 0, 1, "R4 back to idle");
        fetch_op(16'h4321);
        read_op(16'h00A0, 1, 16'h4321, 0, "R4 second serve");

        for (int g = 1; g <= LIM + 2; g++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            bit srv;
            a = AW'(16'h0100 + g);
            d = DW'(g * 16'h1111 + 3);
            srv = (g <= LIM);
            read_op(a, 0, 0, 1, "R6 sweep start");
            fetch_op(d);
            for (int k = 1; k < g; k++) cyc();
            read_op(a, srv, d, !srv, srv ? "R6 served in window" : "R6 R9 late read refetch");
            chk(exp_flag == !srv, "R7 flag after window", exp_flag, !srv);
            if (!srv) begin
                cyc(); cyc(); cyc();
                chk(exp_flag == 1'b1, "R8 sticky", exp_flag, 1);
                exp_clr = 1'b1; cyc(); exp_clr = 1'b0;
                chk(exp_flag == 1'b0, "R8 clear", exp_flag, 0);
                fetch_op(d ^ 16'h00FF);
                read_op(a, 1, d ^ 16'h00FF, 0, "R9 fresh fetch served");
            end
        end

        read_op(16'h0200, 0, 0, 1, "R8 collide start");
        fetch_op(16'h5555);
        for (int k = 1; k < LIM; k++) cyc();
        chk(exp_flag == 0, "R7 not yet expired", exp_flag, 0);
        exp_clr = 1'b1; cyc(); exp_clr = 1'b0;
        chk(exp_flag == 1, "R8 set beats clear", exp_flag, 1);
        read_op(16'h0200, 0, 0, 1, "R7 R9 data discarded");
        exp_clr = 1'b1; cyc(); exp_clr = 1'b0;
        chk(exp_flag == 0, "R8 clear after collide", exp_flag, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule